// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Bank

This block is the host-visible register file of a two-channel, disk-style bus-master DMA controller. It sits behind an I/O-space window of 16 bytes and gives each channel an 8-byte slot. A slot holds a control byte, a status byte and a 32-bit pointer to the descriptor table in memory. The host reaches these through a single-cycle access port that carries an address, an access size (byte, word or dword), a write flag and data. Reads answer one cycle later.

The bank drives the start and direction controls and the table pointer of each channel to a separate DMA engine, and it registers all of them. The engine reports back through one-cycle pulses: completion, error and interrupt. These pulses update the status byte, which mixes several kinds of bit: a read-only activity flag, two sticky event flags that the host clears by writing one, and two plain read/write flags.

Top module: `bmdma_regbank`

## Requirements
- R1: Channel n occupies offsets 8n to 8n+7. Its control and status bytes are at offsets 0 to 3 of the slot and its table pointer is at offsets 4 to 7. A read (acc_valid=1, acc_write=0) raises rd_valid with rd_data on the following cycle. rd_valid stays low in every other cycle.
- R2: At slot offsets 0 to 3, an access with acc_size 1 (word) or 2/3 (dword) is ignored if it is a write. If it is a read, it returns all ones for its width: 0x0000FFFF for a word and 0xFFFFFFFF for a dword.
- R3: A byte read (acc_size 0) returns its value in rd_data[7:0], with the upper bits zero. Slot offset 0 returns the control byte, offset 2 returns the status byte, and offsets 1 and 3 return 0xFF.
- R4: The control byte keeps only bit 0 (start) and bit 3 (direction). Its other bits read as 0. Both bits appear at dma_start and dma_dir.
- R5: Status bit 0 (active) is set by a control write that changes start from 0 to 1. It is cleared by eng_done or by a control write that changes start from 1 to 0. A start from 0 to 1 in the same cycle as eng_done leaves the bit set.
- R6: A status write takes bits 5 and 6 from the data and leaves bit 0 unchanged. A 1 written to bit 1 or bit 2 clears that bit, and a 0 leaves it as it is. Bits 3, 4 and 7 always read as 0.
- R7: The eng_err and eng_irq pulses set status bits 1 and 2. When a pulse arrives in the same cycle as a host write that clears the bit, the bit ends up set.
- R8: The table pointer is 32 bits and bits 1:0 always read as 0. A write of 1, 2 or 4 bytes at slot offset 4+k fills bytes k and upward of the pointer, from acc_wdata[7:0] upward. Bytes that would fall past offset 7 are dropped. A read at offset 4+k returns the pointer shifted right by 8k bits and masked to the access width.
- R9: Reset clears the control byte, the status byte and the pointer of every channel. Channels are independent: an access to one slot, or an engine pulse for one channel, leaves every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte offset within the 16-byte window |
| acc_size | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| acc_wdata | input | 32 | Write data, right-justified |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data, right-justified |
| eng_done | input | 2 | Per-channel completion pulse from the engine |
| eng_err | input | 2 | Per-channel error pulse |
| eng_irq | input | 2 | Per-channel interrupt pulse |
| dma_start | output | 2 | Per-channel start control |
| dma_dir | output | 2 | Per-channel direction control |
| dma_ptr | output | 64 | Descriptor-table pointers, channel n at bits 32n+31:32n |

## Verification
Every register bit that holds wrong state appears on the ports within one cycle. A control or pointer fault shows at once on dma_start, dma_dir or dma_ptr. A status fault shows in the data of the next byte read at offset 2 of the slot. The bench therefore follows each engine pulse and each host write with a read-back or a port check. Its focus is the cases where two updates meet in one cycle: set against clear, start against done, and stop. It also covers writes that must leave a channel untouched, and confirms that by reading the channel back.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_WIDE  = 2'd3
  } acc_size_e;

  localparam int SLOT_LOG2 = 3;
  localparam logic [1:0] SUB_CTL = 2'd0;
  localparam logic [1:0] SUB_ST  = 2'd2;

  localparam int CTL_START = 0;
  localparam int CTL_DIR   = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_IRQ    = 2;
endpackage

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LW     = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        sub,
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] wdata,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_irq,
  output logic              start_o,
  output logic              dir_o,
  output logic [7:0]        status_o,
  output logic [DATA_W-1:0] ptr_o
);
  logic       start_q, dir_q, act_q, err_q, irq_q;
  logic [1:0] st56_q;
  logic       ctl_wr, st_wr, start_rise, start_fall;

  assign ctl_wr     = wr_en && !sub[2] && (size == SZ_BYTE) && (sub[1:0] == SUB_CTL);
  assign st_wr      = wr_en && !sub[2] && (size == SZ_BYTE) && (sub[1:0] == SUB_ST);
  assign start_rise = ctl_wr && wdata[CTL_START] && !start_q;
  assign start_fall = ctl_wr && !wdata[CTL_START] && start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      act_q   <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      st56_q  <= 2'b00;
    end else begin
      if (ctl_wr) begin
        start_q <= wdata[CTL_START];
        dir_q   <= wdata[CTL_DIR];
      end
      if (start_rise)
        act_q <= 1'b1;
      else if (eng_done || start_fall)
        act_q <= 1'b0;
      err_q <= eng_err || (err_q && !(st_wr && wdata[ST_ERR]));
      irq_q <= eng_irq || (irq_q && !(st_wr && wdata[ST_IRQ]));
      if (st_wr)
        st56_q <= wdata[6:5];
    end
  end

  assign start_o  = start_q;
  assign dir_o    = dir_q;
  assign status_o = {1'b0, st56_q, 2'b00, irq_q, err_q, act_q};

  // Pointer: byte-lane writes starting at the addressed lane
  logic [LW-1:0]     lane;
  logic [LW:0]       nbytes;
  logic [DATA_W-1:0] wsh;
  logic [DATA_W-1:0] ptr_q;

  assign lane = sub[LW-1:0];
  assign wsh  = wdata << {lane, 3'b000};

  always_comb begin
    case (size)
      SZ_BYTE: nbytes = (LW+1)'(1);
      SZ_WORD: nbytes = (LW+1)'(2);
      default: nbytes = (LW+1)'(NB);
    endcase
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic be;
    assign be = wr_en && sub[2] && ((LW+1)'(b) >= {1'b0, lane}) &&
                ((LW+1)'(b) < ({1'b0, lane} + nbytes));
    if (b == 0) begin : g_low
      always_ff @(posedge clk) begin
        if (rst)     ptr_q[7:0] <= 8'h00;
        else if (be) ptr_q[7:0] <= wsh[7:0] & 8'hFC;
      end
    end else begin : g_hi
      always_ff @(posedge clk) begin
        if (rst)     ptr_q[8*b +: 8] <= 8'h00;
        else if (be) ptr_q[8*b +: 8] <= wsh[8*b +: 8];
      end
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/bmdma_regbank.sv
module bmdma_regbank
  import bmdma_pkg::*;
#(
  parameter  int NUM_CH = 2,
  parameter  int DATA_W = 32,
  localparam int ADDR_W = $clog2(NUM_CH) + SLOT_LOG2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_valid,
  input  logic                     acc_write,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [1:0]               acc_size,
  input  logic [DATA_W-1:0]        acc_wdata,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  input  logic [NUM_CH-1:0]        eng_done,
  input  logic [NUM_CH-1:0]        eng_err,
  input  logic [NUM_CH-1:0]        eng_irq,
  output logic [NUM_CH-1:0]        dma_start,
  output logic [NUM_CH-1:0]        dma_dir,
  output logic [NUM_CH*DATA_W-1:0] dma_ptr
);
  localparam int CH_W = ADDR_W - SLOT_LOG2;

  logic [CH_W-1:0]   ch_idx;
  logic [2:0]        sub;
  acc_size_e         size;
  logic [7:0]        st_arr  [NUM_CH];
  logic [DATA_W-1:0] ptr_arr [NUM_CH];
  logic [NUM_CH*8-1:0] st_flat;

  assign ch_idx = acc_addr[ADDR_W-1:SLOT_LOG2];
  assign sub    = acc_addr[SLOT_LOG2-1:0];
  assign size   = acc_size_e'(acc_size);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bmdma_chan #(.DATA_W(DATA_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (acc_valid && acc_write && (ch_idx == CH_W'(c))),
      .sub      (sub),
      .size     (size),
      .wdata    (acc_wdata),
      .eng_done (eng_done[c]),
      .eng_err  (eng_err[c]),
      .eng_irq  (eng_irq[c]),
      .start_o  (dma_start[c]),
      .dir_o    (dma_dir[c]),
      .status_o (st_arr[c]),
      .ptr_o    (ptr_arr[c])
    );
    assign dma_ptr[c*DATA_W +: DATA_W] = ptr_arr[c];
    assign st_flat[c*8 +: 8]           = st_arr[c];
  end

  // Read path
  logic [DATA_W-1:0] wmask, rd_next;
  logic [7:0]        ctl_rb;

  always_comb begin
    case (size)
      SZ_BYTE: wmask = DATA_W'(8'hFF);
      SZ_WORD: wmask = DATA_W'(16'hFFFF);
      default: wmask = '1;
    endcase
  end

  assign ctl_rb = {4'b0000, dma_dir[ch_idx], 2'b00, dma_start[ch_idx]};

  always_comb begin
    rd_next = '0;
    if (!sub[2]) begin
      if (size != SZ_BYTE)
        rd_next = wmask;
      else begin
        case (sub[1:0])
          SUB_CTL: rd_next = DATA_W'(ctl_rb);
          SUB_ST:  rd_next = DATA_W'(st_arr[ch_idx]);
          default: rd_next = DATA_W'(8'hFF);
        endcase
      end
    end else begin
      rd_next = (ptr_arr[ch_idx] >> {sub[1:0], 3'b000}) & wmask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write)
        rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/bmdma_regbank_chk.sv
module bmdma_regbank_chk #(
  parameter  int NUM_CH = 2,
  parameter  int DATA_W = 32,
  localparam int ADDR_W = $clog2(NUM_CH) + 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     acc_valid,
  input logic                     acc_write,
  input logic [ADDR_W-1:0]        acc_addr,
  input logic [1:0]               acc_size,
  input logic [DATA_W-1:0]        acc_wdata,
  input logic                     rd_valid,
  input logic [NUM_CH-1:0]        eng_done,
  input logic [NUM_CH-1:0]        eng_err,
  input logic [NUM_CH-1:0]        eng_irq,
  input logic [NUM_CH-1:0]        dma_start,
  input logic [NUM_CH-1:0]        dma_dir,
  input logic [NUM_CH*DATA_W-1:0] dma_ptr,
  input logic [NUM_CH*8-1:0]      st_flat
);
  p_rd_valid_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid);
  p_rd_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && !acc_write) |=> !rd_valid);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic slot_hit, ctl_start_wr;
    assign slot_hit     = acc_valid && acc_write && (acc_addr[ADDR_W-1:3] == (ADDR_W-3)'(c));
    assign ctl_start_wr = slot_hit && (acc_addr[2:0] == 3'd0) && (acc_size == 2'd0) && acc_wdata[0];

    p_wide_ignored_r2: assert property (@(posedge clk) disable iff (rst)
      (slot_hit && !acc_addr[2] && acc_size != 2'd0)
        |=> ($stable(dma_start[c]) && $stable(dma_dir[c])));
    p_active_on_start_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(dma_start[c]) |-> st_flat[c*8]);
    p_done_clears_r5: assert property (@(posedge clk) disable iff (rst)
      (eng_done[c] && !ctl_start_wr) |=> !st_flat[c*8]);
    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (st_flat[c*8+3] == 1'b0) && (st_flat[c*8+4] == 1'b0) && (st_flat[c*8+7] == 1'b0));
    p_err_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
      eng_err[c] |=> st_flat[c*8+1]);
    p_irq_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
      eng_irq[c] |=> st_flat[c*8+2]);
    p_ptr_aligned_r8: assert property (@(posedge clk) disable iff (rst)
      dma_ptr[c*DATA_W +: 2] == 2'b00);
  end
endmodule

bind bmdma_regbank bmdma_regbank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_addr  (acc_addr),
  .acc_size  (acc_size),
  .acc_wdata (acc_wdata),
  .rd_valid  (rd_valid),
  .eng_done  (eng_done),
  .eng_err   (eng_err),
  .eng_irq   (eng_irq),
  .dma_start (dma_start),
  .dma_dir   (dma_dir),
  .dma_ptr   (dma_ptr),
  .st_flat   (st_flat)
);

// File: tb/bmdma_regbank_bench.sv
module bmdma_regbank_bench;
  localparam int NUM_CH = 2;
  localparam int DATA_W = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [1:0]  eng_done = '0, eng_err = '0, eng_irq = '0;
  logic [1:0]  dma_start, dma_dir;
  logic [63:0] dma_ptr;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  bmdma_regbank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bmdma_regbank (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .eng_done(eng_done),
    .eng_err(eng_err), .eng_irq(eng_irq), .dma_start(dma_start),
    .dma_dir(dma_dir), .dma_ptr(dma_ptr));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pop and compare each returned read
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check("R1 unexpected rd_valid", 1, 0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(logic [3:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [1:0] sz, logic [31:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = a; acc_size = sz;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic pulse(int kind, int c);
    @(negedge clk);
    if (kind == 0) eng_done[c] = 1'b1;
    else if (kind == 1) eng_err[c] = 1'b1;
    else eng_irq[c] = 1'b1;
    @(negedge clk);
    eng_done = '0; eng_err = '0; eng_irq = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check("watchdog expired", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    check("R9 start after reset", dma_start, 0);
    check("R9 dir after reset", dma_dir, 0);
    check("R9 ptr after reset", dma_ptr, 0);
    rd(4'h0, 0, 32'h00, "R9 ch0 ctl reset");
    rd(4'h2, 0, 32'h00, "R9 ch0 status reset");
    rd(4'hA, 0, 32'h00, "R9 ch1 status reset");
    rd(4'hC, 2, 32'h0, "R9 ch1 ptr reset");
    // R3 filler offsets
    rd(4'h1, 0, 32'hFF, "R3 offset 1");
    rd(4'hB, 0, 32'hFF, "R3 offset 3 ch1");
    // R4 / R5 control write
    wr(4'h0, 0, 32'h09);
    check("R4 dma_start ch0", dma_start, 2'b01);
    check("R4 dma_dir ch0", dma_dir, 2'b01);
    rd(4'h0, 0, 32'h09, "R3 R4 ctl readback");
    rd(4'h2, 0, 32'h01, "R5 active on start");
    wr(4'h0, 0, 32'hFF);
    rd(4'h0, 0, 32'h09, "R4 unused ctl bits read 0");
    // R2 wide accesses
    rd(4'h0, 1, 32'h0000FFFF, "R2 word read ctl");
    rd(4'h2, 2, 32'hFFFFFFFF, "R2 dword read status");
    wr(4'h0, 2, 32'h0);
    check("R2 wide ctl write ignored", {dma_start, dma_dir}, 4'b0101);
    rd(4'h0, 0, 32'h09, "R2 ctl after wide write");
    // R6 / R7 status semantics
    pulse(1, 0);
    pulse(2, 0);
    rd(4'h2, 0, 32'h07, "R7 err and irq set");
    wr(4'h2, 0, 32'h62);
    rd(4'h2, 0, 32'h65, "R6 w1c bit1, bits 5-6 written");
    wr(4'h2, 0, 32'h04);
    rd(4'h2, 0, 32'h01, "R6 w1c bit2, bits 5-6 cleared");
    wr(4'h2, 0, 32'h99);
    rd(4'h2, 0, 32'h01, "R6 reserved bits and bit0 held");
    pulse(1, 0);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = 4'h2; acc_size = 0; acc_wdata = 32'h02;
    eng_err[0] = 1'b1;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; eng_err = '0;
    rd(4'h2, 0, 32'h03, "R7 set wins over clear");
    // R5 done / stop / restart
    pulse(0, 0);
    rd(4'h2, 0, 32'h02, "R5 done clears active");
    check("R5 start kept after done", dma_start[0], 1);
    wr(4'h0, 0, 32'h08);
    check("R4 stop", {dma_start[0], dma_dir[0]}, 2'b01);
    wr(4'h0, 0, 32'h01);
    rd(4'h2, 0, 32'h03, "R5 restart sets active");
    wr(4'h0, 0, 32'h00);
    rd(4'h2, 0, 32'h02, "R5 stop clears active");
    // R5 start with done in same cycle, ch1
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = 4'h8; acc_size = 0; acc_wdata = 32'h01;
    eng_done[1] = 1'b1;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; eng_done = '0;
    rd(4'hA, 0, 32'h01, "R5 start beats done");
    // R9 channel independence
    pulse(2, 1);
    rd(4'hA, 0, 32'h05, "R7 ch1 irq");
    rd(4'h2, 0, 32'h02, "R9 ch0 untouched by ch1");
    wr(4'hA, 1, 32'hFFFF);
    rd(4'hA, 0, 32'h05, "R2 wide status write ignored");
    // R8 pointer
    wr(4'hC, 2, 32'h12345677);
    check("R8 ptr dword write", dma_ptr[63:32], 32'h12345674);
    rd(4'hC, 2, 32'h12345674, "R8 ptr dword read");
    wr(4'hD, 0, 32'hAB);
    rd(4'hF, 0, 32'h12, "R8 ptr byte read lane 3");
    wr(4'hE, 1, 32'hBEEF);
    rd(4'hC, 1, 32'hAB74, "R8 ptr word read");
    wr(4'hC, 0, 32'hFF);
    check("R8 ptr low bits forced", dma_ptr[63:32], 32'hBEEFABFC);
    wr(4'hF, 1, 32'h5566);
    check("R8 ptr clipped word", dma_ptr[63:32], 32'h66EFABFC);
    check("R9 ch0 ptr untouched", dma_ptr[31:0], 32'h0);
    rd(4'hD, 1, 32'hEFAB, "R8 ptr word read lane 1");
    // R9 reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R9 outputs after reset", {dma_start, dma_dir, dma_ptr}, 0);
    rd(4'hA, 0, 32'h00, "R9 ch1 status after reset");
    repeat (3) @(negedge clk);
    check("R1 all reads returned", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule